// File: doc/BRIEF.md
# Receive Elastic Store with Phase Indicator

This block is a 512-bit receive elastic store organised as two frames of 32 eight-bit timeslots, giving 64 channel slots numbered 0 to 63. Line-side bits enter one at a time through a write stream. The system side pulls bits out through a read stream. Both sides share one clock, and each side moves only when it is strobed.

The block measures how far the read pointer sits from the write pointer. It reports that distance as a 12-bit phase word. The three low bits are fractions of a bit time, formed from a fine-phase tick that runs at eight ticks per read bit. Bit 3 weighs one bit, and every higher bit doubles the weight of the one below it. So bit 6 is one timeslot, bit 10 is sixteen timeslots and bit 11 is one full frame of 256 bits. The resolution is 1/8 bit, which gives an accuracy near 1/16 bit.

The phase word is captured only when the write pointer wraps. Between wraps it holds, so a reader always sees a settled value.

Back-pressure rules: the write stream never stalls, because `in_ready` is always high. Every cycle with `in_valid` high stores one bit. The read stream always offers data, because `out_valid` is always high. `out_bit` shows the bit at the current read address. A cycle with `out_ready` high consumes that bit and advances the read address. Overrun and underrun are not detected; slip handling belongs outside this block.

Top module: `sbpi_top`

## Requirements
- R1: After reset, both pointers and the fine-tick count are zero, and `phase_status` reads 0.
- R2: Each cycle with `in_valid` high writes `in_bit` at the write address. The write address then advances by one, modulo 512.
- R3: `out_bit` shows the stored bit at the read address. Each cycle with `out_ready` high advances the read address by one, modulo 512.
- R4: A write accepted while the write address is 0 captures the phase word. Bits 11:3 take the value (read address − 16 − write address) mod 512, using the read address as it stood before that edge. No other event changes the phase word.
- R5: Bits 2:0 of the phase word take the count of `fine_tick` pulses since the last read strobe, saturating at 7. A read strobe clears the count, and it wins over a tick in the same cycle.
- R6: Bits 15:12 of `phase_status` are always 0.
- R7: `phase_status` holds its value in every cycle that has no capture, whatever the reads, ticks and other writes do.
- R8: `in_ready` and `out_valid` are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write strobe: store `in_bit` this cycle |
| in_ready | output | 1 | Always high; the write stream never stalls |
| in_bit | input | 1 | Line data bit |
| out_valid | output | 1 | Always high; read data is always offered |
| out_ready | input | 1 | Read strobe: consume `out_bit` and advance |
| out_bit | output | 1 | Bit at the current read address |
| fine_tick | input | 1 | Fine-phase tick, eight per read bit |
| phase_status | output | 16 | Phase word in bits 11:0; bits 15:12 are zero |

## Verification
A wrong read or write pointer shows up in two places. It changes which stored bit appears on `out_bit` in the very next cycle. It also shifts bits 11:3 of `phase_status` at the next capture, which comes at most 512 writes later. A wrong fine-tick count appears only in bits 2:0, and only at a capture. So the stimulus always places a capture write right after the reads and ticks it wants to measure. A phase register that loads at the wrong time shows as a `phase_status` change in a cycle with no write at address 0. It is caught by polling the status across long runs of reads, ticks and writes.

// File: rtl/sbpi_pkg.sv
package sbpi_pkg;
  parameter int SLOT_BITS   = 8;
  parameter int FRAME_SLOTS = 32;
  parameter int FRAMES      = 2;
  parameter int FRAC_BITS   = 3;
  parameter int READ_LEAD   = 16;
  parameter int STATUS_W    = 16;
endpackage

// File: rtl/sbpi_store.sv
module sbpi_store #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (!rst_n)  cells <= '0;
    else if (we) cells[waddr] <= wbit;
  end

  assign rbit = cells[raddr];
endmodule

// File: rtl/sbpi_ptr.sv
module sbpi_ptr #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/sbpi_fine.sv
module sbpi_fine #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  output logic [FW-1:0] frac
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   frac <= '0;
    else if (clr)                 frac <= '0;
    else if (tick && frac != '1)  frac <= frac + 1'b1;
  end
endmodule

// File: rtl/sbpi_phase.sv
module sbpi_phase #(
  parameter int AW   = 9,
  parameter int FW   = 3,
  parameter int LEAD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [AW-1:0]    rd_ptr,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [FW-1:0]    frac,
  output logic [AW+FW-1:0] phase
);
  localparam logic [AW-1:0] LEAD_V = AW'(LEAD);
  logic [AW-1:0] sep;

  assign sep = rd_ptr - LEAD_V - wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (capture) phase <= {sep, frac};
  end
endmodule

// File: rtl/sbpi_top.sv
module sbpi_top
  import sbpi_pkg::*;
#(
  parameter int SLOT_W   = SLOT_BITS,
  parameter int SLOTS    = FRAME_SLOTS,
  parameter int NFRAMES  = FRAMES,
  parameter int FW       = FRAC_BITS,
  parameter int LEAD     = READ_LEAD,
  parameter int SW       = STATUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_bit,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit,
  input  logic          fine_tick,
  output logic [SW-1:0] phase_status
);
  localparam int DEPTH = SLOT_W * SLOTS * NFRAMES;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + FW;

  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [FW-1:0] frac;
  logic [PW-1:0] phase;
  logic          capture;

  assign in_ready  = 1'b1;
  assign out_valid = 1'b1;
  assign capture   = in_valid && (wr_ptr == '0);

  sbpi_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(in_valid), .waddr(wr_ptr),
    .wbit(in_bit), .raddr(rd_ptr), .rbit(out_bit)
  );

  sbpi_ptr #(.AW(AW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .step(in_valid), .ptr(wr_ptr)
  );

  sbpi_ptr #(.AW(AW)) u_rptr (
    .clk(clk), .rst_n(rst_n), .step(out_ready), .ptr(rd_ptr)
  );

  sbpi_fine #(.FW(FW)) u_fine (
    .clk(clk), .rst_n(rst_n), .tick(fine_tick), .clr(out_ready), .frac(frac)
  );

  sbpi_phase #(.AW(AW), .FW(FW), .LEAD(LEAD)) u_phase (
    .clk(clk), .rst_n(rst_n), .capture(capture), .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr), .frac(frac), .phase(phase)
  );

  assign phase_status = SW'(phase);
endmodule

// File: rtl/sbpi_chk.sv
module sbpi_chk #(
  parameter int AW = 9,
  parameter int FW = 3,
  parameter int SW = 16,
  parameter int LEAD = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [FW-1:0] frac,
  input logic [SW-1:0] phase_status
);
  localparam logic [AW-1:0] LEAD_V = AW'(LEAD);

  p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wr_ptr == $past(wr_ptr) + 1'b1);

  p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |=> rd_ptr == $past(rd_ptr) + 1'b1);

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wr_ptr == '0) |=>
      phase_status[AW+FW-1:FW] == $past(rd_ptr) - LEAD_V);

  p_frac_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |=> frac == '0);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_status[SW-1:AW+FW] == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && wr_ptr == '0) |=> $stable(phase_status));

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && out_valid);
endmodule

bind sbpi_top sbpi_chk #(.AW(AW), .FW(FW), .SW(SW), .LEAD(LEAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .wr_ptr(wr_ptr),
  .rd_ptr(rd_ptr), .frac(frac), .phase_status(phase_status)
);

// File: tb/test_sbpi_top.sv
module test_sbpi_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0, fine_tick = 1'b0;
  logic in_ready, out_valid, out_bit;
  logic [15:0] phase_status;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sbpi_top i_sbpi_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .fine_tick(fine_tick), .phase_status(phase_status)
  );

  typedef struct packed {
    logic [9:0]  reads;
    logic [3:0]  ticks;
    logic [15:0] exp;
  } vec_t;

  // expected = ((reads - 16) mod 512) * 8 + min(ticks, 7)
  localparam vec_t VECS [8] = '{
    '{10'd0,   4'd0,  16'h0F80},
    '{10'd16,  4'd0,  16'h0000},
    '{10'd17,  4'd3,  16'h000B},
    '{10'd24,  4'd10, 16'h0047},
    '{10'd272, 4'd5,  16'h0805},
    '{10'd144, 4'd1,  16'h0401},
    '{10'd100, 4'd7,  16'h02A7},
    '{10'd528, 4'd2,  16'h0002}
  };
  localparam logic [31:0] PAT = 32'hA5C3_96F1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic b, input logic r, input logic t);
    in_valid = v; in_bit = b; out_ready = r; fine_tick = t;
    @(posedge clk);
    #(CLK_P/4);
    in_valid = 1'b0; out_ready = 1'b0; fine_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    rst_n = 1'b1;
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic writes(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1, R6, R8: reset state
    check("R1 status after reset", 32'(phase_status), 32'h0);
    check("R8 in_ready", 32'(in_ready), 32'h1);
    check("R8 out_valid", 32'(out_valid), 32'h1);

    // R4/R5/R6: vector table; reads, ticks, then one write at address 0
    foreach (VECS[k]) begin
      do_reset();
      reads(int'(VECS[k].reads));
      ticks(int'(VECS[k].ticks));
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      check($sformatf("R4 R5 vector %0d", k), 32'(phase_status), 32'(VECS[k].exp));
      check("R6 upper bits", 32'(phase_status[15:12]), 32'h0);
    end

    // R7: status holds until the write address wraps back to 0
    do_reset();
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 first capture", 32'(phase_status), 32'h0F80);
    reads(20);
    ticks(3);
    writes(200);
    check("R7 hold mid-run", 32'(phase_status), 32'h0F80);
    writes(311);
    check("R7 hold before wrap", 32'(phase_status), 32'h0F80);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 R4 recapture at wrap", 32'(phase_status), 32'h0023);

    // R2/R3: data path, write a pattern then read it back in order
    do_reset();
    for (int i = 0; i < 32; i++) cyc(1'b1, PAT[i], 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      check($sformatf("R2 R3 readback bit %0d", i), 32'(out_bit), 32'(PAT[i]));
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
    end

    // R5: read strobe clears the count and wins over a same-cycle tick
    do_reset();
    ticks(5);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    ticks(2);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R5 clear on read", 32'(phase_status), 32'h0F8A);

    // R4: capture uses the read address before a same-cycle read strobe
    do_reset();
    ticks(3);
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    check("R4 capture with read", 32'(phase_status), 32'h0F83);

    // R4: reads and ticks without a write do not capture
    do_reset();
    reads(20);
    ticks(2);
    check("R4 no capture without write", 32'(phase_status), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule